// File: doc/BRIEF.md
# Segment VSID Scramble Generator

This unit maps an effective address onto a 36-bit virtual segment identifier (VSID). Each request carries an address, a 20-bit context number, and a flag that marks it as a kernel or a user access. The unit first builds a 36-bit proto-identifier. A kernel request uses the segment number of the address as it is. A user request places the context above the low fifteen segment bits.

The proto-identifier is then scattered by a multiplicative hash modulo the Mersenne number 2^36 − 1. The multiplier is the prime 0xFFFFFC7. The reduction uses an end-around fold and no divider. Inputs that fall in the reserved ranges are flagged as errors on the matching response.

The unit is a three-stage pipeline with no back-pressure. It takes one request in every cycle, and each response follows its request three cycles later.

Top module: `vsidGen`

## Requirements
- R1: For a user request (kernel select 0), the proto-identifier is `{context[19:0], ea[42:28]}`. Its bit 35 is therefore 0.
- R2: For a kernel request (kernel select 1), the proto-identifier is `ea[63:28]`.
- R3: A kernel request whose address is below 0xC000000000000000 (ea[63:62] not 11) returns rspErr = 1. This covers the reserved proto prefix 10.
- R4: A kernel request with ea[63:28] all ones returns rspErr = 1, because that proto-identifier is reserved.
- R5: A user request never returns rspErr = 1.
- R6: On a response with rspErr = 0, rspVsid equals (proto × 268435399) mod (2^36 − 1). It is therefore never 0xFFFFFFFFF. On an error response, rspVsid is don't-care.
- R7: A request accepted in one cycle produces rspValid exactly three cycles later. A new request may be accepted in every cycle, and responses come back in request order.
- R8: Synchronous active-high reset clears all pipeline valids, so rspValid is 0 while reset is held and stays 0 until a request has passed through.
- R9: Address bits 27:0 never affect the result. For user requests, address bits 63:43 also have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| reqKernel | input | 1 | 1 selects kernel mapping, 0 selects user mapping |
| reqEa | input | 64 | Effective address |
| reqCtx | input | 20 | Context number (user requests only) |
| rspValid | output | 1 | Response strobe |
| rspVsid | output | 36 | Scrambled segment identifier |
| rspErr | output | 1 | Reserved-input error for this response |

## Verification
The bench applies each request at a falling edge. The request passes through three registers, so its rspValid, rspVsid and rspErr appear after the third rising edge that follows. The bench keeps a three-deep shift line of expected responses. At every falling edge, before it drives the next request, it compares the outputs with the entry that has reached the end of the line. An idle slot checks that rspValid is 0, so a response that comes a cycle early or late is caught as a mismatch in both slots.

// File: rtl/vsidPkg.sv
package vsidPkg;
  localparam int VSID_W = 36;
  localparam int MULT_W = 28;
  localparam int PROD_W = VSID_W + MULT_W;
  localparam logic [MULT_W-1:0] VSID_MULT = 28'hFFFFFC7;
  localparam logic [VSID_W-1:0] VSID_MASK = {VSID_W{1'b1}};
  localparam int PIPE_DEPTH = 3;

  typedef struct packed {
    logic ld1;  // capture proto stage
    logic ld2;  // capture product stage
    logic ld3;  // capture reduced result
  } stageStrobe_t;
endpackage

// File: rtl/vsidCtrl.sv
module vsidCtrl
  import vsidPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  output stageStrobe_t strobe,
  output logic         rspValid
);
  logic [PIPE_DEPTH-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[PIPE_DEPTH-2:0], reqValid};
  end

  always_comb begin
    strobe.ld1 = reqValid;
    strobe.ld2 = vPipe[0];
    strobe.ld3 = vPipe[1];
  end

  assign rspValid = vPipe[PIPE_DEPTH-1];

  // R8
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !rspValid);
endmodule

// File: rtl/vsidDatapath.sv
module vsidDatapath
  import vsidPkg::*;
#(
  parameter int EA_W       = 64,
  parameter int CTX_W      = 20,
  parameter int SEG_SHIFT  = 28,
  parameter int USER_SEG_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  stageStrobe_t      strobe,
  input  logic              reqKernel,
  input  logic [EA_W-1:0]   reqEa,
  input  logic [CTX_W-1:0]  reqCtx,
  output logic [VSID_W-1:0] rspVsid,
  output logic              rspErr
);
  localparam int SEG_W = EA_W - SEG_SHIFT;

  // stage 1: proto formation
  logic [SEG_W-1:0]  segNum;
  logic [VSID_W-1:0] protoNext;
  logic              errNext;
  logic [VSID_W-1:0] proto1;
  logic              err1, kern1;

  assign segNum = reqEa[EA_W-1:SEG_SHIFT];

  always_comb begin
    if (reqKernel) begin
      protoNext = VSID_W'(segNum);
      errNext   = (reqEa[EA_W-1 -: 2] != 2'b11) || (&segNum);
    end else begin
      protoNext = VSID_W'({reqCtx, segNum[USER_SEG_W-1:0]});
      errNext   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.ld1) begin
      proto1 <= protoNext;
      err1   <= errNext;
      kern1  <= reqKernel;
    end
  end

  // stage 2: multiply
  logic [PROD_W-1:0] prod2;
  logic              err2;

  always_ff @(posedge clk) begin
    if (strobe.ld2) begin
      prod2 <= PROD_W'(proto1) * PROD_W'(VSID_MULT);
      err2  <= err1;
    end
  end

  // stage 3: end-around fold modulo 2^VSID_W - 1
  logic [VSID_W:0]   foldSum, foldInc;
  logic [VSID_W-1:0] vsidNext;

  always_comb begin
    foldSum  = (VSID_W+1)'(prod2[PROD_W-1:VSID_W]) + (VSID_W+1)'(prod2[VSID_W-1:0]);
    foldInc  = foldSum + 1'b1;
    vsidNext = foldSum[VSID_W-1:0] + VSID_W'(foldInc[VSID_W]);
  end

  always_ff @(posedge clk) begin
    if (strobe.ld3) begin
      rspVsid <= vsidNext;
      rspErr  <= err2;
    end
  end

  // R5
  user_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.ld2 && !kern1 |-> !err1 && !proto1[VSID_W-1]);

  // R3
  kernel_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.ld2 && kern1 && !err1 |-> proto1[VSID_W-1 -: 2] == 2'b11);

  // R6
  zero_maps_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.ld3 && prod2 == '0 |=> rspVsid == '0);

  // R6
  nonzero_maps_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.ld3 && !err2 && prod2 != '0 |=> rspVsid != '0);

  // R6
  no_reserved_vsid_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.ld3 && !err2 |=> rspVsid != VSID_MASK);
endmodule

// File: rtl/vsidGen.sv
module vsidGen
  import vsidPkg::*;
#(
  parameter int EA_W       = 64,
  parameter int CTX_W      = 20,
  parameter int SEG_SHIFT  = 28,
  parameter int USER_SEG_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqKernel,
  input  logic [EA_W-1:0]   reqEa,
  input  logic [CTX_W-1:0]  reqCtx,
  output logic              rspValid,
  output logic [VSID_W-1:0] rspVsid,
  output logic              rspErr
);
  stageStrobe_t strobe;

  vsidCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  vsidDatapath #(
    .EA_W       (EA_W),
    .CTX_W      (CTX_W),
    .SEG_SHIFT  (SEG_SHIFT),
    .USER_SEG_W (USER_SEG_W)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .reqKernel (reqKernel),
    .reqEa     (reqEa),
    .reqCtx    (reqCtx),
    .rspVsid   (rspVsid),
    .rspErr    (rspErr)
  );
endmodule

// File: tb/sim_vsidGen.sv
`timescale 1ns/1ps
module sim_vsidGen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqKernel = 1'b0;
  logic [63:0] reqEa = '0;
  logic [19:0] reqCtx = '0;
  logic        rspValid;
  logic [35:0] rspVsid;
  logic        rspErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // expected-response shift line, index 2 is due now
  logic        eV[3];
  logic        eErr[3];
  logic [35:0] eVsid[3];
  logic        eSkipVsid[3];

  always #2 clk = ~clk;

  vsidGen u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKernel(reqKernel),
    .reqEa(reqEa), .reqCtx(reqCtx),
    .rspValid(rspValid), .rspVsid(rspVsid), .rspErr(rspErr)
  );

  function automatic logic [35:0] protoOf(logic k, logic [63:0] ea, logic [19:0] ctx);
    if (k) return ea[63:28];
    return {1'b0, ctx, ea[42:28]};
  endfunction

  function automatic logic errOf(logic k, logic [63:0] ea);
    if (!k) return 1'b0;
    return (ea < 64'hC000_0000_0000_0000) || (ea[63:28] == 36'hFFFFFFFFF);
  endfunction

  function automatic logic [35:0] modelVsid(logic [35:0] p);
    logic [63:0] full;
    full = {28'd0, p} * 64'd268435399;
    return 36'(full % 64'h0000_000F_FFFF_FFFF);
  endfunction

  task automatic checkDue(string tag);
    checks++;
    if (rspValid !== eV[2]) begin
      errors++;
      $display("FAIL %s rspValid actual=%b expected=%b", tag, rspValid, eV[2]);
    end else if (eV[2]) begin
      checks++;
      if (rspErr !== eErr[2]) begin
        errors++;
        $display("FAIL %s rspErr actual=%b expected=%b", tag, rspErr, eErr[2]);
      end else if (!eErr[2] && !eSkipVsid[2]) begin
        checks++;
        if (rspVsid !== eVsid[2]) begin
          errors++;
          $display("FAIL %s rspVsid actual=%h expected=%h", tag, rspVsid, eVsid[2]);
        end
      end
    end
  endtask

  // one cycle: check the response now due, then drive a new request
  task automatic step(logic v, logic k, logic [63:0] ea, logic [19:0] ctx, string tag);
    @(negedge clk);
    checkDue(tag);
    eV[2] = eV[1]; eErr[2] = eErr[1]; eVsid[2] = eVsid[1]; eSkipVsid[2] = eSkipVsid[1];
    eV[1] = eV[0]; eErr[1] = eErr[0]; eVsid[1] = eVsid[0]; eSkipVsid[1] = eSkipVsid[0];
    eV[0] = v;
    eErr[0] = errOf(k, ea);
    eVsid[0] = modelVsid(protoOf(k, ea, ctx));
    eSkipVsid[0] = 1'b0;
    reqValid = v; reqKernel = k; reqEa = ea; reqCtx = ctx;
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 64'd0, 20'd0, tag);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      eV[i] = 1'b0; eErr[i] = 1'b0; eVsid[i] = '0; eSkipVsid[i] = 1'b0;
    end
    void'($urandom(32'd1234));
    // R8: reset with request asserted, outputs must stay idle
    reqValid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (rspValid !== 1'b0) begin
        errors++;
        $display("FAIL R8 rspValid in reset actual=%b expected=0", rspValid);
      end
    end
    reqValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 64'd0, 20'd0, "R8");

    // R1/R6 corner protos 0 and 1
    step(1'b1, 1'b0, 64'h0, 20'd0, "R1 proto0");
    step(1'b1, 1'b0, 64'h0000_0000_1000_0000, 20'd0, "R1 proto1");
    step(1'b1, 1'b0, 64'h0000_07FF_F000_0000, 20'hFFFFF, "R1 maxuser");
    // R2/R6 proto 2^36-2
    step(1'b1, 1'b1, 64'hFFFF_FFFF_E000_0000, 20'd0, "R2 protoMax");
    step(1'b1, 1'b1, 64'hC000_0000_0000_0000, 20'd0, "R2 base");
    // R4 all-ones proto
    step(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 20'd5, "R4 allones");
    // R3 below kernel base
    step(1'b1, 1'b1, 64'h8000_0000_0000_0000, 20'd0, "R3 prefix10");
    step(1'b1, 1'b1, 64'hBFFF_FFFF_FFFF_FFFF, 20'd0, "R3 justbelow");
    step(1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0, 20'd0, "R3 low");
    // R5/R9 user with high bits set: same as clean value
    step(1'b1, 1'b0, 64'hFFFF_F800_0000_0000, 20'h00001, "R5 R9 userhigh");
    step(1'b1, 1'b0, 64'h0000_0000_0000_0000, 20'h00001, "R9 userclean");
    // R9 low offset bits ignored
    step(1'b1, 1'b1, 64'hD000_0000_0FFF_FFFF, 20'd0, "R9 offset");
    drain("R7 drain");

    // R7 gaps: isolated request then idle
    step(1'b1, 1'b0, 64'h0000_0123_4000_0000, 20'h0ABCD, "R7 single");
    step(1'b0, 1'b0, 64'd0, 20'd0, "R7 gap");
    step(1'b0, 1'b0, 64'd0, 20'd0, "R7 gap");
    step(1'b1, 1'b1, 64'hE000_0000_0000_0000, 20'd0, "R7 after gap");
    drain("R7 drain");

    // random back-to-back traffic, R6/R7
    for (int n = 0; n < 3000; n++) begin
      logic v, k;
      logic [63:0] ea;
      logic [19:0] ctx;
      v = ($urandom % 8) != 0;
      k = $urandom % 2;
      ea = {$urandom, $urandom};
      if (k && ($urandom % 4 != 0)) ea[63:62] = 2'b11;
      ctx = 20'($urandom);
      step(v, k, ea, ctx, "R6 R7 random");
    end
    drain("R7 drain");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule